// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator and Test Pin Mux

This block compares two pulse trains, a divided reference and a divided feedback from a synthesizer loop, and turns their relative timing into two charge-pump enables: one for sourcing current and one for sinking it. An edge on one input sets its own pending flag; once the other input's edge arrives, both flags clear together. While neither flag is set, both enables are low and the pump output floats. A polarity input chooses which flag drives the source enable, so the same detector fits loops whose oscillator tunes either up or down with control voltage.

The block measures the width of every comparison pulse. It reports lock once a programmable run of consecutive comparisons has stayed at or below a width threshold. A single wider comparison clears the lock at once. The lock indication shares one output pin with a 3-bit test selector. The selector can route the registered reference or feedback pulses to the pin, or either of two divided monitors of the reference edges. The upper half of the code space also forces both pump enables low.

Top module: `pfd_lockmux`

## Requirements
- R1: After reset, src_en_o and snk_en_o are 0, the lock flag is 0, and both reference monitors read 0.
- R2: With pol_i = 1, a rising edge on ref_i that arrives first drives src_en_o to 1 from the next clock edge. It stays 1 until the clock edge at which a rising edge on fb_i is seen.
- R3: With pol_i = 1, a rising edge on fb_i that arrives first drives snk_en_o to 1 in the same way, until the next ref_i edge.
- R4: With pol_i = 0, the roles of R2 and R3 swap: a leading reference edge drives snk_en_o, and a leading feedback edge drives src_en_o.
- R5: Rising edges on both inputs seen at the same clock edge, or a lagging edge that completes a comparison, leave both enables at 0 from that edge on. The two enables are never 1 together.
- R6: While test_code_i[2] = 1, src_en_o and snk_en_o are both 0.
- R7: A comparison's width is the number of cycles its pending flag was high. After LOCK_CNT consecutive comparisons with width at most MAX_W, the lock flag becomes 1. With test_code_i = 000, ld_o shows the lock flag.
- R8: A comparison wider than MAX_W clears the lock flag and restarts the count, at the clock edge that completes that comparison.
- R9: With codes 001 and 101, ld_o equals ref_i delayed by one clock. With codes 010 and 110, ld_o equals fb_i delayed by one clock.
- R10: With code 011, ld_o is the top bit of a modulo-DIV_HI (2048) count of ref_i rising edges since reset. It is 1 for rising-edge counts 1024 to 2047.
- R11: With code 111, ld_o toggles on every ref_i rising edge counted since reset.
- R12: With code 100, ld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Divided reference pulse |
| fb_i | input | 1 | Divided feedback pulse |
| pol_i | input | 1 | Detector polarity |
| test_code_i | input | 3 | Pin selector and pump override code |
| src_en_o | output | 1 | Charge-pump source enable |
| snk_en_o | output | 1 | Charge-pump sink enable |
| ld_o | output | 1 | Shared lock / test pin |

## Verification
An input edge reaches the pending flags, the lock flag, the monitor counters and the registered pulse copies at the first clock edge that samples it. src_en_o, snk_en_o and ld_o are combinational from those registers and from pol_i and test_code_i. The only exception is the override and mux selection, which has no latency. The bench therefore drives inputs at the falling edge. After each rising edge it advances its model of the required behaviour by exactly one step, and then compares all three outputs, so each result is checked in the first cycle it is due.

// File: rtl/pfd_lockmux_pkg.sv
package pfd_lockmux_pkg;
  typedef enum logic [2:0] {
    TM_LOCK      = 3'b000,
    TM_REF       = 3'b001,
    TM_FB        = 3'b010,
    TM_REF_DHI   = 3'b011,
    TM_TRI       = 3'b100,
    TM_TRI_REF   = 3'b101,
    TM_TRI_FB    = 3'b110,
    TM_TRI_DLO   = 3'b111
  } test_mode_e;

  function automatic logic cp_forced_off(logic [2:0] code);
    return code[2];
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o,
  output logic cmp_o,
  output logic ref_rise_o,
  output logic ref_q_o,
  output logic fb_q_o
);
  logic ref_q, fb_q, up_q, dn_q;
  logic ref_rise, fb_rise, up_n, dn_n, both;

  assign ref_rise = ref_i & ~ref_q;
  assign fb_rise  = fb_i & ~fb_q;
  assign up_n     = up_q | ref_rise;
  assign dn_n     = dn_q | fb_rise;
  assign both     = up_n & dn_n;  // reset gate of the two-flop detector

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      ref_q <= ref_i;
      fb_q  <= fb_i;
      up_q  <= up_n & ~both;
      dn_q  <= dn_n & ~both;
    end
  end

  assign up_o       = up_q;
  assign dn_o       = dn_q;
  assign cmp_o      = both;
  assign ref_rise_o = ref_rise;
  assign ref_q_o    = ref_q;
  assign fb_q_o     = fb_q;

  AST_UP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_rise && !fb_rise && !dn_q) |=> up_q); // R2
  AST_PAIR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && fb_rise) |=> (!up_q && !dn_q)); // R5
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_CNT = 4,
  parameter int MAX_W    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic cmp_i,
  output logic lock_o
);
  localparam int RW      = $clog2(MAX_W + 2);
  localparam int GW      = $clog2(LOCK_CNT + 1);
  localparam int RUN_SAT = MAX_W + 1;

  logic [RW-1:0] run_q;
  logic [GW-1:0] good_q;
  logic          lock_q;
  logic          pulse;
  logic [RW:0]   meas;
  logic          wide;

  assign pulse = up_i | dn_i;
  assign meas  = {1'b0, run_q} + (RW+1)'(pulse);
  assign wide  = meas > (RW+1)'(MAX_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cmp_i)
        run_q <= '0;
      else if (pulse && run_q != RW'(RUN_SAT))
        run_q <= run_q + 1'b1;
      if (cmp_i) begin
        if (wide) begin
          good_q <= '0;
          lock_q <= 1'b0;
        end else if (good_q == GW'(LOCK_CNT - 1)) begin
          lock_q <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && wide) |=> !lock_o); // R8
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(cmp_i)); // R7
endmodule

// File: rtl/pfd_mon_div.sv
module pfd_mon_div #(
  parameter int DIV = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic out_o
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign out_o = cnt_q[CW-1];

  AST_DIV_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == '1) |=> (cnt_q == '0)); // R10
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pfd_lockmux.sv
module pfd_lockmux #(
  parameter int LOCK_CNT = 4,
  parameter int MAX_W    = 2,
  parameter int DIV_HI   = 2048,
  parameter int DIV_LO   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic       fb_i,
  input  logic       pol_i,
  input  logic [2:0] test_code_i,
  output logic       src_en_o,
  output logic       snk_en_o,
  output logic       ld_o
);
  import pfd_lockmux_pkg::*;

  logic up, dn, cmp, ref_rise, ref_q, fb_q, lock;
  logic mon_hi, mon_lo, cp_off;
  test_mode_e mode;

  pfd_core u_core (
    .clk_i, .rst_ni, .ref_i, .fb_i,
    .up_o(up), .dn_o(dn), .cmp_o(cmp),
    .ref_rise_o(ref_rise), .ref_q_o(ref_q), .fb_q_o(fb_q)
  );

  pfd_lock_mon #(.LOCK_CNT(LOCK_CNT), .MAX_W(MAX_W)) u_lock (
    .clk_i, .rst_ni, .up_i(up), .dn_i(dn), .cmp_i(cmp), .lock_o(lock)
  );

  pfd_mon_div #(.DIV(DIV_HI)) u_div_hi (
    .clk_i, .rst_ni, .tick_i(ref_rise), .out_o(mon_hi)
  );

  pfd_mon_div #(.DIV(DIV_LO)) u_div_lo (
    .clk_i, .rst_ni, .tick_i(ref_rise), .out_o(mon_lo)
  );

  assign cp_off   = cp_forced_off(test_code_i);
  assign src_en_o = ~cp_off & (pol_i ? up : dn);
  assign snk_en_o = ~cp_off & (pol_i ? dn : up);
  assign mode     = test_mode_e'(test_code_i);

  always_comb begin
    unique case (mode)
      TM_LOCK:                ld_o = lock;
      TM_REF, TM_TRI_REF:     ld_o = ref_q;
      TM_FB, TM_TRI_FB:       ld_o = fb_q;
      TM_REF_DHI:             ld_o = mon_hi;
      TM_TRI:                 ld_o = 1'b0;
      TM_TRI_DLO:             ld_o = mon_lo;
      default:                ld_o = 1'b0;
    endcase
  end

  AST_CP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_en_o && snk_en_o)); // R5
  AST_CP_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_code_i[2] |-> (!src_en_o && !snk_en_o)); // R6
  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_code_i == 3'b100) |-> !ld_o); // R12
endmodule

// File: tb/pfd_lockmux_bench.sv
`timescale 1ns/1ps
module pfd_lockmux_bench;
  localparam int LOCK_CNT = 4;
  localparam int MAX_W    = 2;
  localparam int WD_CYC   = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_i = 1'b0, fb_i = 1'b0, pol_i = 1'b1;
  logic [2:0] test_code_i = 3'b000;
  logic src_en_o, snk_en_o, ld_o;

  int checks = 0, errors = 0, cyc_n = 0;
  bit done = 0;

  // bench model state
  bit mref, mfb, mup, mdn, mlock, mlo, last_cmp, last_wide;
  int mrun, mgood;
  logic [10:0] mhi;

  always #2 clk = ~clk;

  pfd_lockmux #(.LOCK_CNT(LOCK_CNT), .MAX_W(MAX_W)) u_pfd_lockmux (
    .clk_i(clk), .rst_ni, .ref_i, .fb_i, .pol_i, .test_code_i,
    .src_en_o, .snk_en_o, .ld_o
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc_n, act, exp);
    end
  endtask

  function automatic bit exp_ld();
    case (test_code_i)
      3'b000: return mlock;
      3'b001, 3'b101: return mref;
      3'b010, 3'b110: return mfb;
      3'b011: return mhi[10];
      3'b100: return 1'b0;
      default: return mlo;
    endcase
  endfunction

  function automatic string ld_tag();
    case (test_code_i)
      3'b000: return last_wide ? "R8" : "R7";
      3'b011: return "R10";
      3'b100: return "R12";
      3'b111: return "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic string cp_tag();
    if (test_code_i[2]) return "R6";
    if (last_cmp || (!mup && !mdn)) return "R5";
    if (!pol_i) return "R4";
    return mup ? "R2" : "R3";
  endfunction

  task automatic model_step(bit r, bit f);
    bit rr, fr, nu, nd, cmp;
    int w;
    rr = r & ~mref; fr = f & ~mfb;
    nu = mup | rr; nd = mdn | fr; cmp = nu & nd;
    w = mrun + int'(mup | mdn);
    last_cmp = cmp; last_wide = 0;
    if (cmp) begin
      if (w > MAX_W) begin mgood = 0; mlock = 0; last_wide = 1; end
      else if (mgood == LOCK_CNT - 1) mlock = 1;
      else mgood++;
    end
    if (cmp) mrun = 0;
    else if ((mup | mdn) && mrun < MAX_W + 1) mrun++;
    mup = cmp ? 1'b0 : nu;
    mdn = cmp ? 1'b0 : nd;
    if (rr) begin mhi = mhi + 1'b1; mlo = ~mlo; end
    mref = r; mfb = f;
  endtask

  task automatic cyc(bit r, bit f);
    bit tri_off;
    @(negedge clk);
    ref_i = r; fb_i = f;
    @(posedge clk);
    #1;
    cyc_n++;
    model_step(r, f);
    tri_off = test_code_i[2];
    chk(cp_tag(), src_en_o, !tri_off && (pol_i ? mup : mdn));
    chk(cp_tag(), snk_en_o, !tri_off && (pol_i ? mdn : mup));
    chk(ld_tag(), ld_o, exp_ld());
  endtask

  // one comparison: lead_ref selects the leader, d is the edge gap in cycles
  task automatic comp(bit lead_ref, int d);
    if (d == 0) cyc(1, 1);
    else begin
      cyc(lead_ref, !lead_ref);
      for (int i = 1; i < d; i++) cyc(0, 0);
      cyc(!lead_ref, lead_ref);
    end
    cyc(0, 0);
  endtask

  task automatic rand_run(int n, int dens);
    for (int i = 0; i < n; i++)
      cyc(($urandom % dens) == 0, ($urandom % dens) == 0);
  endtask

  initial begin
    #(WD_CYC * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mhi = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", src_en_o, 1'b0);
    chk("R1", snk_en_o, 1'b0);
    chk("R1", ld_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    test_code_i = 3'b011; #0.1; chk("R1", ld_o, 1'b0);
    test_code_i = 3'b111; #0.1; chk("R1", ld_o, 1'b0);
    test_code_i = 3'b000;

    // R2/R3/R7: narrow comparisons lock, pol 1
    pol_i = 1'b1;
    repeat (3) comp(1, 1);
    comp(0, 2);
    comp(1, 0);
    chk("R7", ld_o, 1'b1);
    // R8: one wide comparison drops lock
    comp(1, 5);
    chk("R8", ld_o, 1'b0);
    comp(0, 4);

    // R4: swapped polarity
    pol_i = 1'b0;
    repeat (5) comp(1, 2);
    repeat (5) comp(0, 1);
    comp(0, 3);

    // R6/R9/R12: directed override with pending pulse
    test_code_i = 3'b100; comp(1, 3);
    test_code_i = 3'b101; comp(0, 3);
    test_code_i = 3'b110; comp(1, 2);

    // random sweep across all codes and both polarities
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 2; p++) begin
        test_code_i = 3'(c); pol_i = p[0];
        rand_run(300, 3);
        for (int k = 0; k < 4; k++) comp($urandom % 2, $urandom % 4);
      end

    // R10: long run on the divide-by-2048 monitor
    test_code_i = 3'b011; pol_i = 1'b1;
    rand_run(10000, 2);
    test_code_i = 3'b111;
    rand_run(200, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule